// File: doc/BRIEF.md
# Carry-Skip Adder

A purely combinational adder for two WIDTH-bit operands, split into groups of GROUP bits. Each group ripples its carry through its own adder cells. Alongside the ripple it forms a group-wide propagate flag: every bit's propagate term (the XOR of its two operand bits) is folded through a chain of two-input ANDs. A 2:1 multiplexer at the group's carry output uses that flag as its select. When the flag is set, the group's incoming carry skips straight past the group. When the flag is clear, the group's own rippled carry is used.

There is no carry input. The least significant bit of the whole adder is therefore a half adder, and every other bit is a full adder. When WIDTH is not a multiple of GROUP, the most significant group is narrower than the others.

The result is WIDTH+1 bits wide:
- In unsigned mode, the top bit is the final carry.
- In signed mode, the top bit is the sign of the exact two's-complement sum. It is formed by XORing both operand sign bits with the final carry.

Top module: `skip_adder`

## Requirements
- R1: With SIGNED_MODE=0, `sum_o` equals the unsigned sum of `a_i` and `b_i`, and `sum_o[WIDTH]` is the carry out of the most significant group.
- R2: With SIGNED_MODE=1, `sum_o` equals the two's-complement sum of `a_i` and `b_i`, both sign-extended to WIDTH+1 bits. In particular, `sum_o[WIDTH]` = `a_i[WIDTH-1]` ^ `b_i[WIDTH-1]` ^ final carry.
- R3: When every bit of a group has `a`≠`b`, the group's carry out equals its carry in. For example, `b_i` = ~`a_i` gives `sum_o[WIDTH-1:0]` all ones; the top bit is 0 unsigned, and in signed mode it is 1 (the sum is -1).
- R4: When a group's propagate flag is clear, its carry out is the carry rippled through its cells. For example, `a_i` = `b_i` = all ones gives 2·(2^WIDTH−1) unsigned and −2 signed.
- R5: A WIDTH that is not a multiple of GROUP gives a narrower most significant group, and R1/R2 still hold.
- R6: GROUP=1 (one bit per group) and GROUP≥WIDTH (a single group) both satisfy R1/R2.
- R7: WIDTH=1 satisfies R1/R2, with the single bit built as a half adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH+1 | Sum; top bit is the carry (unsigned) or the sign (signed) |

## Verification
Any wrong internal carry shows up at once as a wrong `sum_o`, because the block has no state. A group's bypass select that picks the wrong source corrupts every higher sum bit, but only for operand pairs whose lower carries differ between the two sources. This is why all-propagate and all-generate operands are applied directly, on top of the exhaustive and random patterns. A fault in the signed top-bit XOR affects only `sum_o[WIDTH]`, and only in signed configurations with mixed operand signs or overflow.

// File: rtl/skip_adder_pkg.sv
package skip_adder_pkg;
  function automatic int group_count(input int width, input int group);
    return (width + group - 1) / group;
  endfunction

  function automatic int top_group_width(input int width, input int group);
    return width - (group_count(width, group) - 1) * group;
  endfunction
endpackage

// File: rtl/skip_adder_cell.sv
module skip_adder_cell #(
  parameter bit HALF = 1'b0
) (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic s_o,
  output logic c_o
);
  assign p_o = a_i ^ b_i;

  generate
    if (HALF) begin : g_half
      assign s_o = p_o;
      assign c_o = a_i & b_i;
      // R7: a half adder cell is only placed where no carry can arrive
      always_comb assert_half_no_cin_R7: assert (c_i === 1'b0 || $isunknown(c_i));
    end else begin : g_full
      assign s_o = p_o ^ c_i;
      assign c_o = (a_i & b_i) | (p_o & c_i);
    end
  endgenerate

  // R1: each cell is an exact one-bit adder
  always_comb
    if (!$isunknown({a_i, b_i, c_i}))
      assert_cell_sum_R1: assert ({c_o, s_o} == {1'b0, a_i} + {1'b0, b_i} + (HALF ? 2'd0 : {1'b0, c_i}));
endmodule

// File: rtl/skip_adder_group.sv
module skip_adder_group #(
  parameter int  BITS  = 4,
  parameter bit  FIRST = 1'b0
) (
  input  logic [BITS-1:0] a_i,
  input  logic [BITS-1:0] b_i,
  input  logic            cin_i,
  output logic [BITS-1:0] sum_o,
  output logic            cout_o
);
  logic [BITS:0]   rip;
  logic [BITS-1:0] prop;
  logic [BITS-1:0] pchain;
  logic            skip_sel;

  assign rip[0] = cin_i;

  genvar i;
  generate
    for (i = 0; i < BITS; i++) begin : g_bit
      skip_adder_cell #(.HALF(FIRST && (i == 0))) u_cell (
        .a_i (a_i[i]),
        .b_i (b_i[i]),
        .c_i (rip[i]),
        .p_o (prop[i]),
        .s_o (sum_o[i]),
        .c_o (rip[i+1])
      );
      if (i == 0) begin : g_p0
        assign pchain[0] = prop[0];
      end else begin : g_pn
        assign pchain[i] = pchain[i-1] & prop[i];
      end
    end
  endgenerate

  assign skip_sel = pchain[BITS-1];
  assign cout_o   = skip_sel ? cin_i : rip[BITS];

  // R3: when all bits propagate, the ripple path agrees with the skip path
  always_comb
    if (!$isunknown({skip_sel, rip[BITS], cin_i}) && skip_sel)
      assert_skip_agrees_R3: assert (rip[BITS] == cin_i);

  // R4: the group result (either carry source) equals a true addition
  always_comb
    if (!$isunknown({a_i, b_i, cin_i}))
      assert_group_sum_R4: assert ({cout_o, sum_o} == {1'b0, a_i} + {1'b0, b_i} + {{BITS{1'b0}}, cin_i});
endmodule

// File: rtl/skip_adder.sv
module skip_adder
  import skip_adder_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int GROUP       = 4,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  localparam int NGRP  = group_count(WIDTH, GROUP);
  localparam int TOPW  = top_group_width(WIDTH, GROUP);

  logic [NGRP:0] gcarry;
  assign gcarry[0] = 1'b0;

  genvar k;
  generate
    for (k = 0; k < NGRP; k++) begin : g_grp
      localparam int LO = k * GROUP;
      localparam int BW = (k == NGRP - 1) ? TOPW : GROUP;
      skip_adder_group #(.BITS(BW), .FIRST(k == 0)) u_grp (
        .a_i    (a_i[LO +: BW]),
        .b_i    (b_i[LO +: BW]),
        .cin_i  (gcarry[k]),
        .sum_o  (sum_o[LO +: BW]),
        .cout_o (gcarry[k+1])
      );
    end

    if (SIGNED_MODE) begin : g_signed
      assign sum_o[WIDTH] = a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ gcarry[NGRP];
      // R2: exact two's-complement sum over WIDTH+1 bits
      always_comb
        if (!$isunknown({a_i, b_i}))
          assert_signed_sum_R2: assert (sum_o == {a_i[WIDTH-1], a_i} + {b_i[WIDTH-1], b_i});
    end else begin : g_unsigned
      assign sum_o[WIDTH] = gcarry[NGRP];
      // R1: exact unsigned sum with carry on top
      always_comb
        if (!$isunknown({a_i, b_i}))
          assert_unsigned_sum_R1: assert (sum_o == {1'b0, a_i} + {1'b0, b_i});
    end
  endgenerate
endmodule

// File: tb/skip_adder_tb.sv
module skip_adder_tb;
  logic clk;
  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic [11:0] va, vb;

  logic [8:0]  r_u84, r_s84;
  logic [7:0]  r_u73, r_s73;
  logic [1:0]  r_u11, r_s11;
  logic [12:0] r_u125, r_s125;
  logic [5:0]  r_u51;
  logic [4:0]  r_s48;

  skip_adder #(.WIDTH(8),  .GROUP(4), .SIGNED_MODE(1'b0)) u_dut    (.a_i(va[7:0]),  .b_i(vb[7:0]),  .sum_o(r_u84));
  skip_adder #(.WIDTH(8),  .GROUP(4), .SIGNED_MODE(1'b1)) u_dut_s84 (.a_i(va[7:0]), .b_i(vb[7:0]),  .sum_o(r_s84));
  skip_adder #(.WIDTH(7),  .GROUP(3), .SIGNED_MODE(1'b0)) u_dut_u73 (.a_i(va[6:0]), .b_i(vb[6:0]),  .sum_o(r_u73));
  skip_adder #(.WIDTH(7),  .GROUP(3), .SIGNED_MODE(1'b1)) u_dut_s73 (.a_i(va[6:0]), .b_i(vb[6:0]),  .sum_o(r_s73));
  skip_adder #(.WIDTH(1),  .GROUP(1), .SIGNED_MODE(1'b0)) u_dut_u11 (.a_i(va[0:0]), .b_i(vb[0:0]),  .sum_o(r_u11));
  skip_adder #(.WIDTH(1),  .GROUP(1), .SIGNED_MODE(1'b1)) u_dut_s11 (.a_i(va[0:0]), .b_i(vb[0:0]),  .sum_o(r_s11));
  skip_adder #(.WIDTH(12), .GROUP(5), .SIGNED_MODE(1'b0)) u_dut_u125 (.a_i(va),     .b_i(vb),       .sum_o(r_u125));
  skip_adder #(.WIDTH(12), .GROUP(5), .SIGNED_MODE(1'b1)) u_dut_s125 (.a_i(va),     .b_i(vb),       .sum_o(r_s125));
  skip_adder #(.WIDTH(5),  .GROUP(1), .SIGNED_MODE(1'b0)) u_dut_u51 (.a_i(va[4:0]), .b_i(vb[4:0]),  .sum_o(r_u51));
  skip_adder #(.WIDTH(4),  .GROUP(8), .SIGNED_MODE(1'b1)) u_dut_s48 (.a_i(va[3:0]), .b_i(vb[3:0]),  .sum_o(r_s48));

  function automatic logic [12:0] ref_sum(input int w, input bit sgn, input logic [11:0] a, input logic [11:0] b);
    logic [12:0] ea, eb, m;
    for (int i = 0; i < 13; i++) begin
      ea[i] = (i < w) ? a[i] : (sgn ? a[w-1] : 1'b0);
      eb[i] = (i < w) ? b[i] : (sgn ? b[w-1] : 1'b0);
      m[i]  = (i <= w);
    end
    return (ea + eb) & m;
  endfunction

  task automatic chk(input string tag, input int w, input bit sgn, input logic [12:0] got);
    logic [12:0] exp;
    exp = ref_sum(w, sgn, va, vb);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s w=%0d signed=%0d a=%h b=%h actual=%h expected=%h", tag, w, sgn, va, vb, got, exp);
    end
  endtask

  task automatic check_all(input string extra);
    chk({"R1 ", extra}, 8, 1'b0, 13'(r_u84));
    chk({"R2 ", extra}, 8, 1'b1, 13'(r_s84));
    chk({"R1/R5 ", extra}, 7, 1'b0, 13'(r_u73));
    chk({"R2/R5 ", extra}, 7, 1'b1, 13'(r_s73));
    chk({"R1/R7 ", extra}, 1, 1'b0, 13'(r_u11));
    chk({"R2/R7 ", extra}, 1, 1'b1, 13'(r_s11));
    chk({"R1/R5 ", extra}, 12, 1'b0, r_u125);
    chk({"R2/R5 ", extra}, 12, 1'b1, r_s125);
    chk({"R1/R6 ", extra}, 5, 1'b0, 13'(r_u51));
    chk({"R2/R6 ", extra}, 4, 1'b1, 13'(r_s48));
  endtask

  task automatic apply(input logic [11:0] a, input logic [11:0] b, input string extra);
    @(posedge clk);
    va = a;
    vb = b;
    @(negedge clk);
    check_all(extra);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    va = '0;
    vb = '0;
    // zero operands: all results zero
    apply(12'h000, 12'h000, "zero");
    // R3: every bit propagates, carries skip every group
    apply(12'h000, 12'hfff, "R3 all-propagate");
    apply(12'ha5c, 12'h5a3, "R3 all-propagate");
    // R4: every bit generates, carries come from the ripple chains
    apply(12'hfff, 12'hfff, "R4 all-generate");
    apply(12'h001, 12'hfff, "R4 long carry");
    apply(12'h800, 12'h800, "R4 sign overflow");
    apply(12'h7ff, 12'h001, "R4 positive overflow");
    // exhaustive over the low byte
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply({$urandom_range(15, 0), 8'(a)}, {$urandom_range(15, 0), 8'(b)}, "exhaustive");
    // random, with half of the vectors biased toward propagating groups
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] ra, rb;
      ra = 12'($urandom());
      rb = (n % 2 == 0) ? 12'($urandom()) : (~ra ^ (12'h1 << $urandom_range(11, 0)));
      apply(ra, rb, "random");
    end
    finish_run();
  end
endmodule